// File: doc/BRIEF.md
# Dual-Scan Monochrome Panel Timing Generator

This block produces every control and data signal needed to refresh a passive monochrome panel that is split into an upper and a lower half, each scanned at the same time through its own 4-bit data path. From the system clock it derives a pixel-time step (Ts) with a selectable divider. From that step it builds a line pulse, a frame pulse, a shift clock that runs at a quarter of the step rate, and a polarity (MOD) signal that alternates once per frame.

Pixel data comes in one byte per shift cycle over a valid/ready fetch port. The high nibble goes to the upper half and the low nibble goes to the lower half. The horizontal display width, the horizontal blanking width (both in 8-pixel units) and the number of lines per half-panel are plain inputs. The block captures all of them, together with the divider select, only when a new frame begins, so a change never splits a line or a frame.

Each line starts at the trailing edge of the line pulse. The line then holds a display stretch of D = (display field + 1) × 8 Ts and a blanking stretch of B = (blanking field + 1) × 8 Ts.

Top module: `lcd_dualscan_tgen`

## Requirements
- R1: With divider select s (0..3), one Ts lasts s+1 clock cycles, so consecutive shift-clock rising edges are 4·(s+1) cycles apart.
- R2: The line period is D+B Ts. The line pulse is high for the last 9 Ts of each line, and its falling edge starts the next line.
- R3: The shift clock rises first 12 Ts after the line-pulse falling edge. It is high for 2 Ts and low for 2 Ts, gives exactly D/4 rising edges per line, and stays low outside the display stretch.
- R4: At each shift rising edge the block takes one byte from the fetch port. The upper output shows bits [7:4] and the lower output shows bits [3:0], and both hold through the next falling edge. When fetch_valid is low the two nibbles are 0. The nibbles are also 0 during blanking.
- R5: The line pulse rises B−19 Ts after the last shift-clock falling edge of the line.
- R6: The frame pulse rises 14 Ts after the line-pulse falling edge that starts the last line of a frame. It falls 14 Ts after the falling edge that starts line 0, so it stays high for one line period.
- R7: A frame holds (line-count field + 1) lines.
- R8: MOD changes state once per frame, exactly one line period minus 1 Ts before the line-pulse falling edge that starts line 0.
- R9: Width, line-count and divider inputs are captured only at a frame boundary. A change made mid-frame leaves the remaining lines of that frame unchanged.
- R10: A blanking field below 2 is treated as 2.
- R11: During reset, and until the first Ts step after reset, every output and fetch_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (memory) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | DIV_W | Ts = div_sel_i+1 clock cycles |
| hdisp_i | input | HD_W | Display width, 8-pixel units minus one |
| hblank_i | input | HB_W | Blanking width, 8-pixel units minus one |
| vlines_i | input | V_W | Lines per half-panel minus one |
| fetch_valid_i | input | 1 | Fetch byte is valid |
| fetch_data_i | input | 8 | [7:4] upper nibble, [3:0] lower nibble |
| fetch_ready_o | output | 1 | Byte is taken on this clock edge |
| frame_o | output | 1 | Frame pulse |
| line_o | output | 1 | Line pulse |
| shift_o | output | 1 | Shift clock |
| mod_o | output | 1 | Polarity alternation |
| upper_o | output | 4 | Upper-half data nibble |
| lower_o | output | 4 | Lower-half data nibble |

## Verification
The hardest case to reach from the ports is a mid-frame configuration change. A new width must not act until the line-pulse falling edge that starts line 0. The bench waits for the frame pulse to fall, which only happens inside line 0, and changes the display width at that point. It then measures the two remaining old-width lines and the first new-width line separately. Divider changes use the same frame-aligned stimulus, so that rising-edge spacing is measured only after the new divider has been captured.

// File: rtl/lcdx_pkg.sv
package lcdx_pkg;
   localparam int LINE_PULSE_TS   = 9;
   localparam int SHIFT_LEAD_TS   = 12;
   localparam int FRAME_HOLD_TS   = 14;
   localparam int MIN_BLANK_UNITS = 2;
   localparam int UNIT_PX         = 8;
   localparam int NIB_PX          = 4;

   // Length in Ts of a field given in 8-pixel units minus one, with a floor.
   function automatic int unsigned span_ts(input int unsigned field, input int unsigned floor_v);
      int unsigned f;
      f = (field < floor_v) ? floor_v : field;
      return (f + 1) * UNIT_PX;
   endfunction
endpackage

// File: rtl/lcdx_pixdiv.sv
module lcdx_pixdiv #(
   parameter bit DIV_EN = 1'b1,
   parameter int DIV_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (DIV_EN) begin : g_div
         logic [DIV_W-1:0] cnt;
         assign tick_o = (cnt >= div_i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (tick_o) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
         // R1: a divided step never repeats on the following cycle
         p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
      end else begin : g_bypass
         logic unused_div;
         assign unused_div = ^div_i;
         assign tick_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lcdx_htiming.sv
module lcdx_htiming import lcdx_pkg::*; #(
   parameter int H_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_i,
   input  logic           run_i,
   input  logic [H_W-1:0] d_len_i,
   input  logic [H_W-1:0] b_len_i,
   output logic [H_W-1:0] h_o,
   output logic           h_last_o,
   output logic           line_o,
   output logic           shift_o,
   output logic           load_o,
   output logic           clr_o
);
   localparam logic [H_W-1:0] LP  = H_W'(LINE_PULSE_TS);
   localparam logic [H_W-1:0] SL  = H_W'(SHIFT_LEAD_TS);
   localparam logic [H_W-1:0] SL1 = H_W'(SHIFT_LEAD_TS - 1);

   logic [H_W-1:0] h, p_len, hs, hl;

   assign p_len    = d_len_i + b_len_i;
   assign h_last_o = (h == p_len - 1'b1);
   assign h_o      = h;
   assign hs       = h - SL;
   assign hl       = h - SL1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               h <= '0;
      else if (tick_i && run_i) h <= h_last_o ? '0 : h + 1'b1;
   end

   assign line_o  = run_i && (h >= p_len - LP);
   assign shift_o = run_i && (h >= SL) && (h < SL + d_len_i) && !hs[1];
   assign load_o  = tick_i && run_i && (h >= SL1) && (h < SL1 + d_len_i) && (hl[1:0] == 2'b00);
   assign clr_o   = tick_i && run_i && (h == SL1 + d_len_i);

   // R3: shift clock never overlaps the line pulse
   p_shift_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_o |-> !line_o);
   // R2: line pulse lasts beyond a single clock
   p_pulse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_o) |=> line_o);
endmodule

// File: rtl/lcdx_vtiming.sv
module lcdx_vtiming import lcdx_pkg::*; #(
   parameter int H_W = 11,
   parameter int V_W = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_i,
   input  logic           run_i,
   input  logic           h_last_i,
   input  logic [H_W-1:0] h_i,
   input  logic [V_W-1:0] v_max_i,
   output logic [V_W-1:0] vline_o,
   output logic           frame_end_o,
   output logic           frame_o,
   output logic           mod_o
);
   localparam logic [H_W-1:0] FH = H_W'(FRAME_HOLD_TS);

   logic [V_W-1:0] v;
   logic           v_last;

   assign v_last      = (v == v_max_i);
   assign frame_end_o = h_last_i && v_last;
   assign vline_o     = v;
   assign frame_o     = run_i && ((v_last && h_i >= FH) || (v == '0 && h_i < FH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v     <= '0;
         mod_o <= 1'b0;
      end else if (tick_i && run_i) begin
         if (h_last_i) v <= v_last ? '0 : v + 1'b1;
         if (v_last && h_i == '0) mod_o <= ~mod_o;
      end
   end

   // R8: polarity changes only during the last line of a frame
   p_mod_last_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(mod_o) |-> v_last);
   // R7: line index stays within the captured frame height
   p_line_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      v <= v_max_i);
endmodule

// File: rtl/lcd_dualscan_tgen.sv
module lcd_dualscan_tgen import lcdx_pkg::*; #(
   parameter bit DIV_EN = 1'b1,
   parameter int DIV_W  = 2,
   parameter int HD_W   = 7,
   parameter int HB_W   = 5,
   parameter int V_W    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_sel_i,
   input  logic [HD_W-1:0]  hdisp_i,
   input  logic [HB_W-1:0]  hblank_i,
   input  logic [V_W-1:0]   vlines_i,
   input  logic             fetch_valid_i,
   input  logic [7:0]       fetch_data_i,
   output logic             fetch_ready_o,
   output logic             frame_o,
   output logic             line_o,
   output logic             shift_o,
   output logic             mod_o,
   output logic [3:0]       upper_o,
   output logic [3:0]       lower_o
);
   localparam int P_MAX = ((1 << HD_W) + (1 << HB_W)) * UNIT_PX;
   localparam int H_W   = $clog2(P_MAX) + 1;

   initial begin : elab_chk
      if (DIV_W < 1 || HD_W < 1 || V_W < 1) $fatal(1, "width parameters must be positive");
      if (HB_W < 2) $fatal(1, "blanking field must hold the minimum blanking value");
   end

   logic             tick, run, cfg_load, h_last, load, clr, frame_end;
   logic [H_W-1:0]   d_q, b_q, h;
   logic [V_W-1:0]   v_q, vline;
   logic [DIV_W-1:0] div_q;

   assign cfg_load = tick && (!run || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         d_q   <= H_W'(span_ts(0, 0));
         b_q   <= H_W'(span_ts(0, MIN_BLANK_UNITS));
         v_q   <= '0;
         div_q <= '0;
      end else if (cfg_load) begin
         run   <= 1'b1;
         d_q   <= H_W'(span_ts(32'(hdisp_i), 0));
         b_q   <= H_W'(span_ts(32'(hblank_i), MIN_BLANK_UNITS));
         v_q   <= vlines_i;
         div_q <= div_sel_i;
      end
   end

   lcdx_pixdiv #(.DIV_EN(DIV_EN), .DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick));

   lcdx_htiming #(.H_W(H_W)) u_h (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
      .d_len_i(d_q), .b_len_i(b_q), .h_o(h), .h_last_o(h_last),
      .line_o(line_o), .shift_o(shift_o), .load_o(load), .clr_o(clr));

   lcdx_vtiming #(.H_W(H_W), .V_W(V_W)) u_v (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
      .h_last_i(h_last), .h_i(h), .v_max_i(v_q), .vline_o(vline),
      .frame_end_o(frame_end), .frame_o(frame_o), .mod_o(mod_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_o <= '0;
         lower_o <= '0;
      end else if (load) begin
         upper_o <= fetch_valid_i ? fetch_data_i[7:4] : 4'h0;
         lower_o <= fetch_valid_i ? fetch_data_i[3:0] : 4'h0;
      end else if (clr) begin
         upper_o <= '0;
         lower_o <= '0;
      end
   end

   assign fetch_ready_o = load;

   // R4: a taken byte is followed by a shift rising edge
   p_ready_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ready_o |=> $rose(shift_o));
   // R9: captured widths change only as line 0 begins
   p_cfg_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(d_q) && run && $past(run)) |-> (h == '0 && vline == '0));
   // R6: frame pulse edges fall outside the line pulse
   p_frame_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(frame_o) |-> !line_o);
   // R11: nothing toggles before the first step
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !(line_o || shift_o || frame_o || fetch_ready_o));
endmodule

// File: tb/tb_lcd_dualscan_tgen.sv
module tb_lcd_dualscan_tgen;
   localparam int LF = 0, LR = 1, SR = 2, SF = 3, FR = 4, FF = 5, MC = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ds = 2'd0;
   logic [6:0] hd = 7'd0;
   logic [4:0] hb = 5'd2;
   logic [9:0] vl = 10'd2;
   logic       fvalid = 1'b1;
   logic [7:0] fdata = 8'h5A;
   logic       fready, frame_o, line_o, shift_o, mod_o;
   logic [3:0] upper_o, lower_o;

   int chk = 0, err = 0, dchk = 0, derr = 0, cyc = 0;
   int ev_n [0:6];
   int ev_t [0:6];
   logic [7:0] cap = 8'h00, last_rise = 8'h00;
   logic pend = 1'b0;
   logic pl = 1'b0, ps = 1'b0, pf = 1'b0, pm = 1'b0;

   always #2 clk = ~clk;

   lcd_dualscan_tgen dut (
      .clk(clk), .rst_n(rst_n), .div_sel_i(ds), .hdisp_i(hd), .hblank_i(hb),
      .vlines_i(vl), .fetch_valid_i(fvalid), .fetch_data_i(fdata),
      .fetch_ready_o(fready), .frame_o(frame_o), .line_o(line_o),
      .shift_o(shift_o), .mod_o(mod_o), .upper_o(upper_o), .lower_o(lower_o));

   initial for (int i = 0; i < 7; i++) begin ev_n[i] = 0; ev_t[i] = 0; end

   // Edge recorder and data source / checker (R4)
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (line_o && !pl)  begin ev_n[LR]++; ev_t[LR] = cyc;
            dchk++;
            if ({upper_o, lower_o} != 8'h00) begin derr++;
               $display("FAIL R4 blank nibbles act=%h exp=00", {upper_o, lower_o}); end
         end
         if (!line_o && pl)  begin ev_n[LF]++; ev_t[LF] = cyc; end
         if (shift_o && !ps) begin ev_n[SR]++; ev_t[SR] = cyc;
            dchk++;
            last_rise = {upper_o, lower_o};
            if ({upper_o, lower_o} != cap) begin derr++;
               $display("FAIL R4 nibbles act=%h exp=%h", {upper_o, lower_o}, cap); end
         end
         if (!shift_o && ps) begin ev_n[SF]++; ev_t[SF] = cyc; end
         if (frame_o && !pf) begin ev_n[FR]++; ev_t[FR] = cyc; end
         if (!frame_o && pf) begin ev_n[FF]++; ev_t[FF] = cyc; end
         if (mod_o != pm)    begin ev_n[MC]++; ev_t[MC] = cyc; end
         if (pend) begin fdata = fdata + 8'h37; pend = 1'b0; end
         if (fready) begin cap = fvalid ? fdata : 8'h00; pend = 1'b1; end
      end
      pl = line_o; ps = shift_o; pf = frame_o; pm = mod_o;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      chk++;
      if (!ok) begin err++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
   endtask

   task automatic wait_evt(input int which);
      int n0;
      n0 = ev_n[which];
      do @(posedge clk); while (ev_n[which] == n0);
   endtask

   task automatic settle();
      wait_evt(FF); wait_evt(FF);
   endtask

   task automatic t_reset();
      repeat (5) @(negedge clk);
      check(!(fready || frame_o || line_o || shift_o || mod_o) && upper_o == 0 && lower_o == 0,
            "R11 outputs in reset", {fready, frame_o, line_o, shift_o, mod_o}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_line();
      int t0, n0;
      wait_evt(LF); t0 = ev_t[LF]; n0 = ev_n[SR];
      wait_evt(SR); check(ev_t[SR] - t0 == 12, "R3 first rise", ev_t[SR] - t0, 12);
      wait_evt(SF); check(ev_t[SF] - ev_t[SR] == 2, "R3 high width", ev_t[SF] - ev_t[SR], 2);
      wait_evt(SR); check(ev_t[SR] - ev_t[SF] == 2, "R3 low width", ev_t[SR] - ev_t[SF], 2);
      wait_evt(LR);
      check(ev_t[LR] - ev_t[SF] == 5, "R5 last fall to pulse", ev_t[LR] - ev_t[SF], 5);
      check(ev_t[LR] - t0 == 23, "R2 pulse start", ev_t[LR] - t0, 23);
      wait_evt(LF);
      check(ev_t[LF] - t0 == 32, "R2 line period", ev_t[LF] - t0, 32);
      check(ev_t[LF] - ev_t[LR] == 9, "R2 pulse width", ev_t[LF] - ev_t[LR], 9);
      check(ev_n[SR] - n0 == 2, "R3 rises per line", ev_n[SR] - n0, 2);
   endtask

   task automatic t_fetch_gap();
      @(negedge clk); fvalid = 1'b0;
      wait_evt(LF); wait_evt(LF);
      check(last_rise == 8'h00, "R4 invalid fetch gives zero", last_rise, 0);
      @(negedge clk); fvalid = 1'b1;
      wait_evt(LF); wait_evt(SR);
      check(derr == 0, "R4 nibble mapping", derr, 0);
   endtask

   task automatic t_frame();
      int tf, nl;
      wait_evt(FF); tf = ev_t[FF]; nl = ev_n[LF];
      check(ev_t[FF] - ev_t[LF] == 14, "R6 hold after line 0 start", ev_t[FF] - ev_t[LF], 14);
      wait_evt(FR);
      check(ev_t[FR] - ev_t[LF] == 14, "R6 rise in last line", ev_t[FR] - ev_t[LF], 14);
      wait_evt(FF);
      check(ev_t[FF] - ev_t[FR] == 32, "R6 frame width", ev_t[FF] - ev_t[FR], 32);
      check(ev_n[LF] - nl == 3, "R7 lines per frame", ev_n[LF] - nl, 3);
      check(ev_t[FF] - tf == 96, "R7 frame period", ev_t[FF] - tf, 96);
   endtask

   task automatic t_mod();
      int tm;
      wait_evt(MC); tm = ev_t[MC];
      wait_evt(LF);
      check(ev_t[LF] - tm == 31, "R8 lead before line 0", ev_t[LF] - tm, 31);
      wait_evt(MC);
      check(ev_t[MC] - tm == 96, "R8 once per frame", ev_t[MC] - tm, 96);
   endtask

   task automatic t_div(input logic [1:0] s);
      int t0;
      @(negedge clk); ds = s;
      settle();
      wait_evt(LF); t0 = ev_t[LF];
      wait_evt(SR);
      check(ev_t[SR] - t0 == 12 * (s + 1), "R1 lead scaled", ev_t[SR] - t0, 12 * (s + 1));
      t0 = ev_t[SR];
      wait_evt(SR);
      check(ev_t[SR] - t0 == 4 * (s + 1), "R1 shift period", ev_t[SR] - t0, 4 * (s + 1));
   endtask

   task automatic t_midframe();
      int t1, t2, t3, n3;
      wait_evt(FF);
      @(negedge clk); hd = 7'd1;
      wait_evt(LF); t1 = ev_t[LF];
      wait_evt(LF); t2 = ev_t[LF];
      check(t2 - t1 == 32, "R9 line 1 keeps old width", t2 - t1, 32);
      wait_evt(LF); t3 = ev_t[LF]; n3 = ev_n[SR];
      check(t3 - t2 == 32, "R9 last line keeps old width", t3 - t2, 32);
      wait_evt(LF);
      check(ev_t[LF] - t3 == 40, "R9 new width at frame", ev_t[LF] - t3, 40);
      check(ev_n[SR] - n3 == 4, "R3 rises at wider line", ev_n[SR] - n3, 4);
      @(negedge clk); hd = 7'd0;
      settle();
   endtask

   task automatic t_clamp();
      int t0;
      @(negedge clk); hb = 5'd0;
      settle();
      wait_evt(LF); t0 = ev_t[LF]; wait_evt(LF);
      check(ev_t[LF] - t0 == 32, "R10 blanking floor", ev_t[LF] - t0, 32);
      @(negedge clk); hb = 5'd3;
      settle();
      wait_evt(LF); t0 = ev_t[LF]; wait_evt(LR);
      check(ev_t[LR] - ev_t[SF] == 13, "R5 wider blanking", ev_t[LR] - ev_t[SF], 13);
      wait_evt(LF);
      check(ev_t[LF] - t0 == 40, "R10 above floor", ev_t[LF] - t0, 40);
      @(negedge clk); hb = 5'd2;
      settle();
   endtask

   initial begin : watchdog
      #(4 * 150000);
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", err + derr + 1, chk + dchk + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_line();
      t_fetch_gap();
      t_frame();
      t_mod();
      t_midframe();
      t_clamp();
      t_div(2'd2);
      t_div(2'd3);
      @(negedge clk);
      check(derr == 0, "R4 data stream", derr, 0);
      $display("Result: errors=%0d of %0d checks", err + derr, chk + dchk);
      $finish;
   end
endmodule